// File: doc/BRIEF.md
# External Interrupt Source Multiplexer

This block sits between the general-purpose input ports of a chip and the external interrupt edge detector. It takes a flat vector of pin levels from several 16-pin ports, where the pin level for port p, pin k sits at index p × 16 + k. It produces sixteen interrupt line levels. Line n always follows pin n of one port, and a 4-bit port-select field for that line picks the port. Select value 0 picks the first port.

The sixteen select fields are held in four 32-bit configuration words. Each word carries four fields in its low 16 bits, and the upper 16 bits are discarded on write. Line n uses word n / 4, field position n mod 4, at bits 4 × (n mod 4) + 3 down to 4 × (n mod 4). The stored words can be read back through a combinational read port.

The output vector is a combinational function of the pins and the stored fields. The downstream detector sees a new routing in the cycle after a configuration write. A select value naming a port beyond the supported count holds its line low. Edge detection, masking and pending state belong to the downstream detector.

Top module: `extimux_top`

## Requirements
- R1: After reset every stored configuration word reads back as zero, and line n follows input n (the first port) for all n.
- R2: A write with `cfgWe` high at a rising clock edge loads word `cfgAddr`. Line n takes its select from bits [4(n mod 4)+3 : 4(n mod 4)] of word n/4, and the new routing is visible after that edge.
- R3: Bits 31 to 16 of a written word are discarded, and they read back as zero.
- R4: With select value s below the port count (8 by default), line n equals input s × 16 + n.
- R5: A select value of 8 or more drives its line low whatever the inputs are, and this includes the boundary value 8.
- R6: Raising input k of the selected port asserts only line k, and all other lines are unchanged.
- R7: Inputs of ports that are not selected for a line have no effect on that line.
- R8: `cfgRdata` returns the low 16 bits of word `cfgRaddr`, zero-extended, with no clock delay.
- R9: A change on `pinIn` appears on `lineOut` without waiting for a clock edge.
- R10: With `cfgWe` low, a clock edge leaves every stored word unchanged, whatever `cfgAddr` and `cfgWdata` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration writes |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write enable |
| cfgAddr | input | 2 | Index of the configuration word to write |
| cfgWdata | input | 32 | Configuration write data; only bits 15:0 are kept |
| cfgRaddr | input | 2 | Index of the configuration word to read |
| cfgRdata | output | 32 | Read-back of the selected configuration word |
| pinIn | input | 128 | Pin levels, index = port × 16 + pin |
| lineOut | output | 16 | Interrupt line levels to the edge detector |

## Verification
The bench builds the block with its default parameters: sixteen lines, four select fields per word, and eight ports of sixteen pins. With these values, the highest in-range select value (7, index 124 for line 12) and the first out-of-range values (8 and 9) are both reachable. Rows in the bench table rewrite one word at a time. The bench then compares the full 16-bit output against a model driven by shadow copies of the words, so any line that moves when it should not is caught. Directed tests cover reset, a write with the enable low, and a pin change between clock edges.

// File: rtl/extimux_pkg.sv
package extimux_pkg;
  localparam int CFG_WORDS      = 4;
  localparam int CFG_FIELD_BITS = 16;

  typedef struct packed {
    logic [CFG_WORDS-1:0]      wordLoad;
    logic [CFG_FIELD_BITS-1:0] loadData;
  } cfgStrobe_t;
endpackage

// File: rtl/extimux_ctrl.sv
module extimux_ctrl
  import extimux_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int NUM_WORDS = CFG_WORDS,
  parameter int FIELD_BITS = CFG_FIELD_BITS,
  localparam int ADDR_W = $clog2(NUM_WORDS)
) (
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [WORD_W-1:0] cfgWdata,
  output cfgStrobe_t        strobe
);
  // One load strobe per configuration word, decoded from the address.
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_dec
    assign strobe.wordLoad[w] = cfgWe && (cfgAddr == ADDR_W'(w));
  end
  // Upper bits of the write data are dropped here.
  assign strobe.loadData = cfgWdata[FIELD_BITS-1:0];
endmodule

// File: rtl/extimux_datapath.sv
module extimux_datapath
  import extimux_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int NUM_PORTS = 8,
  parameter int PINS_PER_PORT = 16,
  parameter int SEL_W = 4,
  parameter int WORD_W = 32,
  parameter int NUM_WORDS = CFG_WORDS,
  parameter int FIELD_BITS = CFG_FIELD_BITS,
  localparam int FIELDS_PER_WORD = FIELD_BITS / SEL_W,
  localparam int ADDR_W = $clog2(NUM_WORDS),
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int IN_W = NUM_PORTS * PINS_PER_PORT
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cfgStrobe_t           strobe,
  input  logic [ADDR_W-1:0]    cfgRaddr,
  output logic [WORD_W-1:0]    cfgRdata,
  input  logic [IN_W-1:0]      pinIn,
  output logic [NUM_LINES-1:0] lineOut
);
  logic [FIELD_BITS-1:0] cfgWord [NUM_WORDS];

  // Select-word storage, one register per word.
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   cfgWord[w] <= '0;
      else if (strobe.wordLoad[w]) cfgWord[w] <= strobe.loadData;
    end
  end

  assign cfgRdata = WORD_W'(cfgWord[cfgRaddr]);

  // Per-line port mux: line n only ever sees pin n of each port.
  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    localparam int WIDX = n / FIELDS_PER_WORD;
    localparam int FPOS = n % FIELDS_PER_WORD;
    logic [SEL_W-1:0]     selField;
    logic [NUM_PORTS-1:0] candidate;
    logic [PORT_W-1:0]    portIdx;
    logic                 inRange;

    assign selField = cfgWord[WIDX][FPOS*SEL_W +: SEL_W];
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      assign candidate[p] = pinIn[p*PINS_PER_PORT + n];
    end
    assign inRange = (32'(selField) < NUM_PORTS);
    assign portIdx = PORT_W'(selField);
    assign lineOut[n] = inRange && candidate[portIdx];
  end
endmodule

// File: rtl/extimux_top.sv
module extimux_top
  import extimux_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int NUM_PORTS = 8,
  parameter int PINS_PER_PORT = 16,
  parameter int SEL_W = 4,
  parameter int WORD_W = 32,
  localparam int ADDR_W = $clog2(CFG_WORDS),
  localparam int IN_W = NUM_PORTS * PINS_PER_PORT
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic [ADDR_W-1:0]    cfgAddr,
  input  logic [WORD_W-1:0]    cfgWdata,
  input  logic [ADDR_W-1:0]    cfgRaddr,
  output logic [WORD_W-1:0]    cfgRdata,
  input  logic [IN_W-1:0]      pinIn,
  output logic [NUM_LINES-1:0] lineOut
);
  cfgStrobe_t strobe;

  extimux_ctrl #(
    .WORD_W(WORD_W), .NUM_WORDS(CFG_WORDS), .FIELD_BITS(CFG_FIELD_BITS)
  ) u_ctrl (
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata), .strobe(strobe)
  );

  extimux_datapath #(
    .NUM_LINES(NUM_LINES), .NUM_PORTS(NUM_PORTS), .PINS_PER_PORT(PINS_PER_PORT),
    .SEL_W(SEL_W), .WORD_W(WORD_W), .NUM_WORDS(CFG_WORDS),
    .FIELD_BITS(CFG_FIELD_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgRaddr(cfgRaddr),
    .cfgRdata(cfgRdata), .pinIn(pinIn), .lineOut(lineOut)
  );
endmodule

// File: rtl/extimux_chk.sv
module extimux_chk #(
  parameter int NUM_LINES = 16,
  parameter int NUM_PORTS = 8,
  parameter int PINS_PER_PORT = 16,
  parameter int SEL_W = 4,
  parameter int WORD_W = 32,
  parameter int FIELD_BITS = 16,
  parameter int ADDR_W = 2,
  localparam int FPW = FIELD_BITS / SEL_W,
  localparam int IN_W = NUM_PORTS * PINS_PER_PORT,
  localparam int LINE_W = $clog2(NUM_LINES),
  localparam int IDX_W = $clog2(IN_W) + 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 cfgWe,
  input logic [ADDR_W-1:0]    cfgAddr,
  input logic [WORD_W-1:0]    cfgWdata,
  input logic [ADDR_W-1:0]    cfgRaddr,
  input logic [WORD_W-1:0]    cfgRdata,
  input logic [IN_W-1:0]      pinIn,
  input logic [NUM_LINES-1:0] lineOut
);
  // R3: discarded upper bits never read back
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdata[WORD_W-1:FIELD_BITS] == '0);

  // R2 / R8: a write lands and is visible on the read port next cycle
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgRaddr == cfgAddr) |=>
      (cfgRaddr != $past(cfgRaddr) ||
       cfgRdata == WORD_W'($past(cfgWdata[FIELD_BITS-1:0]))));

  // R10: no write enable, no change
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWe |=> (cfgRaddr != $past(cfgRaddr) || $stable(cfgRdata)));

  // R4 / R5: lines governed by the word on the read port match its fields
  for (genvar f = 0; f < FPW; f++) begin : g_fld
    logic [SEL_W-1:0]  fld;
    logic [LINE_W-1:0] lineIdx;
    logic [IDX_W-1:0]  pinIdx;
    assign fld     = cfgRdata[f*SEL_W +: SEL_W];
    assign lineIdx = LINE_W'(32'(cfgRaddr) * FPW + f);
    assign pinIdx  = IDX_W'(32'(fld) * PINS_PER_PORT + 32'(lineIdx));

    a_r4_route: assert property (@(posedge clk) disable iff (!rstN)
      (32'(fld) < NUM_PORTS) |-> lineOut[lineIdx] == pinIn[pinIdx[$clog2(IN_W)-1:0]]);

    a_r5_out_of_range_low: assert property (@(posedge clk) disable iff (!rstN)
      (32'(fld) >= NUM_PORTS) |-> !lineOut[lineIdx]);
  end
endmodule

bind extimux_top extimux_chk #(
  .NUM_LINES(NUM_LINES), .NUM_PORTS(NUM_PORTS), .PINS_PER_PORT(PINS_PER_PORT),
  .SEL_W(SEL_W), .WORD_W(WORD_W), .FIELD_BITS(extimux_pkg::CFG_FIELD_BITS),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
  .cfgRaddr(cfgRaddr), .cfgRdata(cfgRdata), .pinIn(pinIn), .lineOut(lineOut)
);

// File: tb/extimux_top_tb.sv
`timescale 1ns/1ps
module extimux_top_tb;
  localparam int NL = 16;
  localparam int NP = 8;
  localparam int PP = 16;
  localparam int IN_W = NP * PP;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            cfgWe = 1'b0;
  logic [1:0]      cfgAddr = '0;
  logic [31:0]     cfgWdata = '0;
  logic [1:0]      cfgRaddr = '0;
  logic [31:0]     cfgRdata;
  logic [IN_W-1:0] pinIn = '0;
  logic [NL-1:0]   lineOut;

  int nRun = 0;
  int nFail = 0;
  logic [15:0] shadow [4];

  always #2.5 clk = ~clk;

  extimux_top u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .cfgRaddr(cfgRaddr), .cfgRdata(cfgRdata), .pinIn(pinIn), .lineOut(lineOut)
  );

  typedef struct packed {
    logic [1:0]      addr;
    logic [31:0]     data;
    logic [IN_W-1:0] pins;
  } row_t;

  localparam int NROWS = 8;
  localparam row_t TABLE [NROWS] = '{
    '{2'd0, 32'h0000_0010, IN_W'(1) << 17},           // R2 R4: line 1 from port B pin 1
    '{2'd0, 32'h0000_0001, IN_W'(1) << 0},            // R7: port A pin 0 ignored by line 0
    '{2'd0, 32'h0000_0001, IN_W'(1) << 16},           // R4: line 0 from port B pin 0
    '{2'd3, 32'h0000_0007, IN_W'(1) << 124},          // R4: line 12 from port H
    '{2'd1, 32'h0000_9000, {IN_W{1'b1}}},             // R5: select 9 holds line 7 low
    '{2'd2, 32'hFFFF_2222, IN_W'(1) << 41},           // R3: upper half discarded, port C
    '{2'd0, 32'h0000_0000, IN_W'(1) << 2},            // R6: only line 2 rises
    '{2'd1, 32'h0000_8000, {IN_W{1'b1}}}              // R5: boundary select 8
  };

  function automatic logic [NL-1:0] model(input logic [IN_W-1:0] p);
    logic [NL-1:0] r;
    for (int n = 0; n < NL; n++) begin
      int s;
      s = int'(shadow[n/4][(n%4)*4 +: 4]);
      r[n] = (s < NP) ? p[s*PP + n] : 1'b0;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeWord(input logic [1:0] a, input logic [31:0] d, input logic we);
    @(negedge clk);
    cfgWe = we; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
    if (we) shadow[a] = d[15:0];
  endtask

  initial begin
    #2_000_000;
    nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    for (int w = 0; w < 4; w++) shadow[w] = '0;
    pinIn = {8{16'hA5C3}};
    repeat (3) @(negedge clk);
    // R1: reset state, lines follow port A
    check(lineOut == pinIn[15:0], "R1", 128'(lineOut), 128'(pinIn[15:0]));
    rstN = 1'b1;
    @(negedge clk);
    for (int w = 0; w < 4; w++) begin
      cfgRaddr = 2'(w);
      #0.1;
      check(cfgRdata == 32'h0, "R1", 128'(cfgRdata), 128'h0);
    end

    // Table walk
    for (int i = 0; i < NROWS; i++) begin
      writeWord(TABLE[i].addr, TABLE[i].data, 1'b1);
      pinIn = TABLE[i].pins;
      cfgRaddr = TABLE[i].addr;
      #1;
      check(cfgRdata == {16'h0, TABLE[i].data[15:0]}, "R8 R3",
            128'(cfgRdata), 128'({16'h0, TABLE[i].data[15:0]}));
      check(lineOut == model(pinIn), "R2 R4 R5 R6 R7",
            128'(lineOut), 128'(model(pinIn)));
    end

    // R5: line 7 low with all ones, others follow
    check(lineOut[7] == 1'b0, "R5", 128'(lineOut[7]), 128'h0);

    // R10: write with enable low leaves words unchanged
    writeWord(2'd1, 32'h0000_3333, 1'b0);
    cfgRaddr = 2'd1;
    #1;
    check(cfgRdata == 32'h0000_8000, "R10", 128'(cfgRdata), 128'h8000);

    // R9: pin change between edges appears at once
    writeWord(2'd0, 32'h0000_0000, 1'b1);
    @(negedge clk);
    pinIn = '0;
    #1;
    check(lineOut == model(pinIn), "R9", 128'(lineOut), 128'(model(pinIn)));
    pinIn[3] = 1'b1;
    #1;
    check(lineOut == 16'h0008, "R9 R6", 128'(lineOut), 128'h0008);

    // R7: port B pin 0 ignored while line 0 selects port A
    pinIn = IN_W'(1) << 16;
    #1;
    check(lineOut[0] == 1'b0, "R7", 128'(lineOut[0]), 128'h0);

    // R1: reset in the middle of a run clears words
    writeWord(2'd2, 32'h0000_5555, 1'b1);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    cfgRaddr = 2'd2;
    pinIn = {8{16'h1234}};
    #1;
    check(cfgRdata == 32'h0, "R1", 128'(cfgRdata), 128'h0);
    check(lineOut == 16'h1234, "R1", 128'(lineOut), 128'h1234);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule